// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a stored SDRAM mode word into the column address sequence of one read or write burst. A load strobe captures the mode word; the block decodes from it the burst length, the ordering (sequential or interleaved), the CAS latency field and the write-mode bit, and raises an illegal-mode flag whenever any of those fields holds a reserved code. A start pulse with a start column then launches a burst: the block presents one column per beat and moves to the next column on each cycle in which the advance enable is high.

Fixed bursts of 1, 2, 4 or 8 beats wrap inside their aligned block of columns, either by counting or by XOR with the beat index. A full-page burst counts through the whole page, wraps at its end and keeps running until a terminate request cuts it off. When the write-mode bit is set, write bursts are reduced to a single beat while read bursts keep the programmed length. The command pins, data path and latency timing belong to the surrounding controller.

Top module: `burst_col_gen`

## Requirements
- R1: The mode word (12 bits) is captured on a clock with `mode_ld` high. Fields: bits 2..0 length code (000=1, 001=2, 010=4, 011=8, 111=full page), bit 3 ordering (0 sequential, 1 interleaved), bits 6..4 CAS latency (only 010 and 011 legal), bit 9 write mode. `mode_bad` is high, from the cycle after the load, when the length code is 100, 101 or 110, when it is 111 with bit 3 set, or when the CAS latency code is neither 010 nor 011. After reset the stored word is all zero, so `mode_bad` reads 1.
- R2: A `start` pulse sampled while `mode_bad` is low makes `beat_valid` high from the next cycle, with `col` equal to the sampled `start_col`.
- R3: While `beat_valid` is high and `adv` is low, `col`, `beat_valid` and `beat_last` hold; each cycle with `adv` high moves to the next beat.
- R4: Sequential bursts of length L (1, 2, 4, 8) give on beat k the start column with its low log2(L) bits replaced by (those bits + k) mod L; the upper bits stay fixed.
- R5: Interleaved bursts give on beat k the start column with its low log2(L) bits XORed with k.
- R6: A full-page burst gives start column + k modulo 2^COL_W on beat k, wrapping from the last column to 0, and never ends by itself.
- R7: With bit 9 set, a burst launched with `is_write` high has one beat at the start column; a burst launched with `is_write` low uses the programmed length.
- R8: `beat_last` is high on the final beat of a fixed-length burst; after that beat is accepted with `adv` high, `beat_valid` is low in the next cycle.
- R9: `term` high during a valid beat makes that beat the last one (`beat_last` high); it ends the burst when accepted.
- R10: A `start` pulse sampled while `mode_bad` is high is ignored: no beat appears.
- R11: Loading a new mode word during a burst leaves the length and ordering of that burst unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_ld | input | 1 | Capture `mode_word` into the mode register |
| mode_word | input | 12 | Mode word to store |
| is_write | input | 1 | Burst launched by `start` is a write |
| start | input | 1 | Launch a burst |
| start_col | input | COL_W | First column of the burst |
| term | input | 1 | End the burst at the current beat |
| adv | input | 1 | Accept the current beat and advance |
| col | output | COL_W | Column of the current beat |
| beat_valid | output | 1 | A beat is being presented |
| beat_last | output | 1 | The current beat is the final one |
| mode_bad | output | 1 | Stored mode word holds a reserved field value |

## Verification
The bench builds the block with its default column width of 9 bits, so a page is 512 columns and a full-page burst started a few columns before the page end reaches the wrap to column 0 within a handful of beats. The same width makes every fixed length from 1 to 8 beats fit with spare upper bits, so the check that upper column bits stay fixed while the low bits wrap is meaningful. Every length code, both orderings, the write-mode reduction and a mid-burst mode reload are driven against a queue of expected columns and last flags.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  localparam int MODE_W = 12;
  localparam int LEN_LSB = 0;
  localparam int ORD_BIT = 3;
  localparam int LAT_LSB = 4;
  localparam int WRM_BIT = 9;

  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

  // lg: log2 of the fixed length, page: run until terminated, ilv: XOR order
  typedef struct packed {
    logic [1:0] lg;
    logic       page;
    logic       ilv;
  } burst_cfg_t;

endpackage

// File: rtl/burst_mode_dec.sv
module burst_mode_dec
  import burst_col_pkg::*;
(
  input  logic [MODE_W-1:0] mode_q,
  input  logic              is_write,
  output burst_cfg_t        cfg,
  output logic              bad
);

  logic [2:0] len_code;
  logic [2:0] lat_code;
  logic       len_bad;
  logic       lat_bad;
  logic       single;

  always_comb begin
    len_code = mode_q[LEN_LSB +: 3];
    lat_code = mode_q[LAT_LSB +: 3];
    single   = mode_q[WRM_BIT] & is_write;
    cfg.ilv  = mode_q[ORD_BIT];
    cfg.lg   = 2'd0;
    cfg.page = 1'b0;
    len_bad  = 1'b0;
    case (len_code)
      LEN_1:    cfg.lg = 2'd0;
      LEN_2:    cfg.lg = 2'd1;
      LEN_4:    cfg.lg = 2'd2;
      LEN_8:    cfg.lg = 2'd3;
      LEN_PAGE: begin
        cfg.page = 1'b1;
        len_bad  = mode_q[ORD_BIT];
      end
      default:  len_bad = 1'b1;
    endcase
    lat_bad = !((lat_code == 3'b010) || (lat_code == 3'b011));
    if (single) begin
      cfg.lg   = 2'd0;
      cfg.page = 1'b0;
    end
    bad = len_bad | lat_bad;
  end

  logic unused_mode_bits;
  assign unused_mode_bits = ^{mode_q[MODE_W-1:WRM_BIT+1], mode_q[WRM_BIT-1:LAT_LSB+3]};

endmodule

// File: rtl/burst_col_calc.sv
module burst_col_calc #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] xor_col;

  always_comb begin
    seq_col = (base & ~mask) | ((base + beat) & mask);
    xor_col = base ^ (beat & mask);
    col     = ilv ? xor_col : seq_col;
  end

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  burst_cfg_t       cfg_in,
  input  logic             bad,
  input  logic             adv,
  input  logic             term,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] mask,
  output logic             ilv,
  output logic             active,
  output logic             last
);

  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic             active_q, active_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [COL_W-1:0] beat_q, beat_d;
  burst_cfg_t       cfg_q, cfg_d;
  logic             launch;
  logic             upd_en;
  logic [COL_W-1:0] len_onehot;

  always_comb begin
    len_onehot = ONE << cfg_q.lg;
    mask       = cfg_q.page ? '1 : (len_onehot - ONE);
    last       = active_q & (term | (!cfg_q.page & (beat_q == mask)));
    launch     = start & !bad;
    upd_en     = launch | (active_q & adv);

    active_d = active_q;
    base_d   = base_q;
    beat_d   = beat_q;
    cfg_d    = cfg_q;
    if (launch) begin
      active_d = 1'b1;
      base_d   = start_col;
      beat_d   = '0;
      cfg_d    = cfg_in;
    end else if (active_q & adv) begin
      if (last) active_d = 1'b0;
      else      beat_d   = beat_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      beat_q   <= '0;
      cfg_q    <= '0;
    end else if (upd_en) begin
      active_q <= active_d;
      base_q   <= base_d;
      beat_q   <= beat_d;
      cfg_q    <= cfg_d;
    end
  end

  assign base   = base_q;
  assign beat   = beat_q;
  assign ilv    = cfg_q.ilv;
  assign active = active_q;

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ld,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              is_write,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              term,
  input  logic              adv,
  output logic [COL_W-1:0]  col,
  output logic              beat_valid,
  output logic              beat_last,
  output logic              mode_bad
);

  logic [1:0]        rst_pipe;
  logic              rst_n_s;
  logic [MODE_W-1:0] mode_q;
  burst_cfg_t        cfg;
  logic [COL_W-1:0]  base;
  logic [COL_W-1:0]  beat;
  logic [COL_W-1:0]  mask;
  logic              ilv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     mode_q <= '0;
    else if (mode_ld) mode_q <= mode_word;
  end

  burst_mode_dec u_dec (
    .mode_q   (mode_q),
    .is_write (is_write),
    .cfg      (cfg),
    .bad      (mode_bad)
  );

  burst_seq #(.COL_W(COL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start     (start),
    .start_col (start_col),
    .cfg_in    (cfg),
    .bad       (mode_bad),
    .adv       (adv),
    .term      (term),
    .base      (base),
    .beat      (beat),
    .mask      (mask),
    .ilv       (ilv),
    .active    (beat_valid),
    .last      (beat_last)
  );

  burst_col_calc #(.COL_W(COL_W)) u_calc (
    .base (base),
    .beat (beat),
    .mask (mask),
    .ilv  (ilv),
    .col  (col)
  );

endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic             term,
  input logic             adv,
  input logic [COL_W-1:0] col,
  input logic             beat_valid,
  input logic             beat_last,
  input logic             mode_bad
);

  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
    start && !mode_bad |=> beat_valid && (col == $past(start_col)));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !adv && !start |=> beat_valid && $stable(col) && $stable(beat_last));

  a_r8_end: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last && adv && !start |=> !beat_valid);

  a_r9_term: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && term |-> beat_last);

  a_r10_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    start && mode_bad && !beat_valid |=> !beat_valid);

endmodule

bind burst_col_gen burst_col_chk #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .start      (start),
  .start_col  (start_col),
  .term       (term),
  .adv        (adv),
  .col        (col),
  .beat_valid (beat_valid),
  .beat_last  (beat_last),
  .mode_bad   (mode_bad)
);

// File: tb/sim_burst_col_gen.sv
`timescale 1ns/1ps
module sim_burst_col_gen;

  localparam int COL_W = 9;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mode_ld = 1'b0;
  logic [11:0]      mode_word = '0;
  logic             is_write = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic             term = 1'b0;
  logic             adv = 1'b1;
  logic [COL_W-1:0] col;
  logic             beat_valid;
  logic             beat_last;
  logic             mode_bad;

  always #10 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_word(mode_word),
    .is_write(is_write), .start(start), .start_col(start_col), .term(term),
    .adv(adv), .col(col), .beat_valid(beat_valid), .beat_last(beat_last),
    .mode_bad(mode_bad)
  );

  typedef struct {
    int    c;
    bit    last;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // bench copy of the stored mode fields
  int m_len = 0, m_ord = 0, m_lat = 0, m_wrm = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic [11:0] mw(input int lat, input int ord, input int len, input int wrm);
    logic [11:0] w;
    w = '0;
    w[2:0] = len[2:0];
    w[3]   = ord[0];
    w[6:4] = lat[2:0];
    w[9]   = wrm[0];
    return w;
  endfunction

  function automatic bit bad_model(input int lat, input int ord, input int len);
    return (len >= 4 && len <= 6) || (len == 7 && ord == 1) || !(lat == 2 || lat == 3);
  endfunction

  function automatic int exp_col(input int b, input int k, input int blen, input bit page, input bit ilv);
    int lo, top;
    if (page) return (b + k) % PAGE;
    lo  = b % blen;
    top = b - lo;
    if (ilv) return top + (lo ^ k);
    return top + ((lo + k) % blen);
  endfunction

  task automatic load_mode(input int lat, input int ord, input int len, input int wrm);
    mode_ld = 1'b1;
    mode_word = mw(lat, ord, len, wrm);
    @(posedge clk); #1;
    mode_ld = 1'b0;
    m_len = len; m_ord = ord; m_lat = lat; m_wrm = wrm;
    @(negedge clk);
    chk(mode_bad == bad_model(lat, ord, len), "R1 mode_bad", mode_bad, bad_model(lat, ord, len));
  endtask

  task automatic push_burst(input int b, input bit wr, input int nbeats, input string tag);
    int  blen;
    bit  page;
    page = (m_len == 7) && !(wr && m_wrm == 1);
    blen = (wr && m_wrm == 1) ? 1 : (1 << m_len);
    for (int k = 0; k < nbeats; k++) begin
      exp_t e;
      e.c = exp_col(b, k, page ? PAGE : blen, page, (m_ord == 1) && !page);
      e.last = (k == nbeats - 1);
      e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  // term_beat < 0: no terminate; nbeats is then the programmed length
  task automatic run_burst(input int b, input bit wr, input int nbeats, input int term_beat,
                           input bit stall, input string tag);
    push_burst(b, wr, nbeats, tag);
    is_write = wr;
    start_col = COL_W'(b);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (term_beat >= 0) begin
      repeat (term_beat) begin @(posedge clk); #1; end
      term = 1'b1;
      @(posedge clk); #1;
      term = 1'b0;
    end
    if (stall) begin
      while (exp_q.size() != 0) begin
        adv = 1'b0;
        @(posedge clk); #1;
        adv = 1'b1;
        @(posedge clk); #1;
      end
    end
    wait (exp_q.size() == 0);
    @(negedge clk);
    chk(beat_valid == 1'b0, {"R8 burst end ", tag}, beat_valid, 0);
    @(posedge clk); #1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && beat_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected beat", col, -1);
      end else begin
        chk(col == exp_q[0].c, {exp_q[0].tag, " col"}, col, exp_q[0].c);
        chk(beat_last == exp_q[0].last, {exp_q[0].tag, " last"}, beat_last, exp_q[0].last);
        if (adv) void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    @(negedge clk);
    chk(beat_valid == 1'b0, "R1 reset valid", beat_valid, 0);
    chk(beat_last == 1'b0, "R1 reset last", beat_last, 0);
    chk(mode_bad == 1'b1, "R1 reset mode_bad", mode_bad, 1);
    @(posedge clk); #1;

    // R10: start with reserved mode is ignored
    load_mode(3, 0, 5, 0);
    start_col = 9'h010; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    @(negedge clk);
    chk(beat_valid == 1'b0, "R10 start ignored", beat_valid, 0);
    @(posedge clk); #1;

    // R1: reserved codes
    load_mode(3, 0, 4, 0);
    load_mode(3, 0, 6, 0);
    load_mode(3, 1, 7, 0);
    load_mode(1, 0, 3, 0);
    load_mode(4, 0, 3, 0);
    load_mode(2, 1, 7, 0);
    start_col = 9'h020; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    @(negedge clk);
    chk(beat_valid == 1'b0, "R10 start ignored page ilv", beat_valid, 0);
    @(posedge clk); #1;

    // R4 sequential lengths
    load_mode(3, 0, 3, 0);
    run_burst(9'h0D5, 0, 8, -1, 0, "R4 seq8");
    load_mode(2, 0, 2, 0);
    run_burst(9'h0D5, 0, 4, -1, 0, "R4 seq4");
    load_mode(2, 0, 1, 0);
    run_burst(9'h0D5, 0, 2, -1, 0, "R4 seq2");
    load_mode(3, 0, 0, 0);
    run_burst(9'h0D5, 0, 1, -1, 0, "R4 seq1");

    // R5 interleaved
    load_mode(3, 1, 3, 0);
    run_burst(9'h1A3, 0, 8, -1, 0, "R5 ilv8");
    load_mode(2, 1, 2, 0);
    run_burst(9'h1A3, 0, 4, -1, 0, "R5 ilv4");

    // R3 stalls
    load_mode(2, 0, 2, 0);
    run_burst(9'h0AE, 0, 4, -1, 1, "R3 stall");

    // R6 full page wraps, R9 terminate
    load_mode(3, 0, 7, 0);
    run_burst(9'h1FC, 0, 8, 7, 0, "R6 R9 page wrap");

    // R9 terminate inside a fixed burst
    load_mode(3, 0, 3, 0);
    run_burst(9'h041, 0, 3, 2, 0, "R9 term fixed");

    // R7 write mode
    load_mode(3, 0, 3, 1);
    run_burst(9'h065, 1, 1, -1, 0, "R7 single write");
    run_burst(9'h065, 0, 8, -1, 0, "R7 read full len");
    load_mode(3, 0, 3, 0);
    run_burst(9'h065, 1, 8, -1, 0, "R7 burst write");

    // R11 mode reload mid-burst
    load_mode(3, 0, 3, 0);
    push_burst(9'h0D5, 0, 8, "R11 reload");
    is_write = 1'b0; start_col = 9'h0D5; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    @(posedge clk); #1;
    mode_ld = 1'b1; mode_word = mw(2, 1, 1, 0);
    @(posedge clk); #1; mode_ld = 1'b0;
    m_len = 1; m_ord = 1; m_lat = 2; m_wrm = 0;
    wait (exp_q.size() == 0);
    @(negedge clk);
    chk(beat_valid == 1'b0, "R11 burst end", beat_valid, 0);
    @(posedge clk); #1;
    run_burst(9'h0D5, 0, 2, -1, 0, "R11 new mode");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule